// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the device side of the program path in a small-page NAND memory model. A host presents bytes on a shared input bus and marks each one with a strobe: a command strobe, an address strobe, a data-in strobe or a read strobe. A program runs as a load command, four address cycles and a series of data bytes into a page buffer, then a confirm command. The device then drops its ready line for a set number of cycles, folds the buffer into the addressed page by bitwise AND, and checks the result.

During the program period the device accepts only the status and reset commands. A status byte reports ready, write protect and the pass/fail result of the last program. Each page counts its partial programs and refuses any beyond the limit. A stuck-at-one cell, placed by parameters, gives the verify step a real fault to find. A plain page read (pointer command, four address cycles, read strobes) makes the array visible at the ports.

Top module: `nps_prog_seq`

## Requirements
- R1: A program is the command 80h, four address strobes (1st: column byte, 2nd: row byte whose low bits pick the page, 3rd and 4th: ignored), data strobes, then 10h. Ready goes low on the cycle after the 10h strobe and stays low for PROG_CYCLES (default 16) cycles. Each addressed byte then holds old AND loaded.
- R2: The pointer command 01h selects the second half, so a later column byte c addresses column 256+c. 00h selects the first half. Data fills the buffer from that column upward. Data strobes past the last column (COLS-1 = 527) are ignored.
- R3: 10h is ignored unless an 80h sequence is pending and has loaded at least one data byte. Ready stays high and the array is unchanged.
- R4: While ready is low, only 70h and FFh are accepted. Every other command, address strobe and data strobe is ignored, and the program ends as if they had not occurred.
- R5: The status byte has bit 7 equal to the write-protect input, bit 6 equal to 1 when ready and 0 when busy, bit 0 equal to 1 when the last program failed, and bits 5..1 equal to 0.
- R6: After 70h, the output shows the status byte and read strobes do not move the pointer. This lasts until another accepted command arrives.
- R7: Buffer bytes that were never loaded hold FFh and leave the array unchanged. A bit that is already 0 stays 0 when the new data has 1 there, and this is not a failure.
- R8: Verify sets the fail bit only when a bit meant to go from 1 to 0 reads 1 afterwards. The cell at page STUCK_PAGE (3), column STUCK_COL (5), bit STUCK_BIT (0) always reads 1.
- R9: Each page accepts at most MAX_PARTIAL (8) programs after reset. A further program on that page still runs the busy period, sets the fail bit and leaves the page unchanged. Other pages are not affected.
- R10: FFh during the busy period makes ready high on the next cycle. It leaves the array and the partial count unchanged, clears the fail bit and drops the loaded data, so a following 10h starts nothing.
- R11: After 00h or 01h and four address strobes, the output shows the addressed byte and each read strobe advances the column. Past the last column it reads FFh. After reset every byte reads FFh.
- R12: After reset, ready is high and the output is not in status mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Latch din as a command |
| addr_we | input | 1 | Latch din as an address cycle |
| data_we | input | 1 | Latch din as a data byte |
| rd_stb | input | 1 | Read strobe: advance the read column |
| din | input | 8 | Shared command/address/data bus |
| wp_n | input | 1 | Write-protect level reported in status bit 7 |
| dout | output | 8 | Status byte or array byte at the pointer |
| ready | output | 1 | High when ready, low during the program period |

## Verification
Each strobe is registered on one rising edge. Its effect shows at the ports one cycle later, because dout and ready are decoded from registers. The bench drives on falling edges and samples on the next falling edge. The busy length is counted in falling edges with ready low, which must equal PROG_CYCLES. The array result is read back through the read path only once ready is high again. Aborts and ignored commands are judged by the ready level one cycle after the strobe and by a read-back afterwards.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } nps_state_e;

  localparam logic [7:0] OP_PTR_LO  = 8'h00;
  localparam logic [7:0] OP_PTR_HI  = 8'h01;
  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  typedef struct packed {
    logic ptr_lo;
    logic ptr_hi;
    logic load;
    logic confirm;
    logic status;
    logic reset;
  } nps_cmd_t;

endpackage

// File: rtl/nps_cmd_decode.sv
module nps_cmd_decode
  import nps_pkg::*;
(
  input  logic       cmd_we,
  input  logic [7:0] code,
  input  logic       busy,
  output nps_cmd_t   cmd,
  output logic       any
);

  nps_cmd_t raw;

  always_comb begin
    raw         = '0;
    raw.ptr_lo  = cmd_we && (code == OP_PTR_LO);
    raw.ptr_hi  = cmd_we && (code == OP_PTR_HI);
    raw.load    = cmd_we && (code == OP_LOAD);
    raw.confirm = cmd_we && (code == OP_CONFIRM);
    raw.status  = cmd_we && (code == OP_STATUS);
    raw.reset   = cmd_we && (code == OP_RESET);
    cmd = raw;
    // while the program period runs only status and reset get through
    if (busy) begin
      cmd.ptr_lo  = 1'b0;
      cmd.ptr_hi  = 1'b0;
      cmd.load    = 1'b0;
      cmd.confirm = 1'b0;
    end
    any = |cmd;
  end

endmodule

// File: rtl/nps_page_buf.sv
module nps_page_buf #(
  parameter int COLS = 528,
  parameter int CW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [CW-1:0]     col,
  input  logic [7:0]        din,
  output logic [COLS*8-1:0] bits
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [7:0] byte_q;
    logic       hit;

    assign hit = we && (col == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'hFF;
      end else if (clr) begin
        byte_q <= 8'hFF;
      end else if (hit) begin
        byte_q <= din;
      end
    end

    assign bits[c*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/nps_array.sv
module nps_array #(
  parameter int PAGES       = 4,
  parameter int COLS        = 528,
  parameter int PW          = 2,
  parameter int CW          = 10,
  parameter int MAX_PARTIAL = 8,
  parameter int STUCK_PAGE  = 3,
  parameter int STUCK_COL   = 5,
  parameter int STUCK_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PW-1:0]     page,
  input  logic [COLS*8-1:0] data,
  input  logic [CW-1:0]     rd_col,
  output logic [7:0]        rd_byte,
  output logic              prog_fail
);

  localparam int              CNTW    = $clog2(MAX_PARTIAL + 1);
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(MAX_PARTIAL);
  localparam logic [CW-1:0]   COL_END = CW'(COLS);

  logic [7:0]      mem [PAGES][COLS];
  logic [CNTW-1:0] cnt [PAGES];
  logic [7:0]      new_b [COLS];
  logic            limit;
  logic            vfail;

  // next page image and one-directional verify
  always_comb begin
    limit = cnt[page] >= CNT_MAX;
    vfail = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      new_b[c] = mem[page][c] & data[c*8 +: 8];
      if ((int'(page) == STUCK_PAGE) && (c == STUCK_COL)) begin
        new_b[c][STUCK_BIT] = 1'b1;
      end
      if (|(~data[c*8 +: 8] & new_b[c])) begin
        vfail = 1'b1;
      end
    end
    prog_fail = limit | vfail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) begin
        cnt[p] <= '0;
        for (int c = 0; c < COLS; c++) begin
          mem[p][c] <= 8'hFF;
        end
      end
    end else if (commit && !limit) begin
      cnt[page] <= cnt[page] + CNTW'(1);
      for (int c = 0; c < COLS; c++) begin
        mem[page][c] <= new_b[c];
      end
    end
  end

  assign rd_byte = (rd_col < COL_END) ? mem[page][rd_col] : 8'hFF;

endmodule

// File: rtl/nps_prog_seq.sv
module nps_prog_seq
  import nps_pkg::*;
#(
  parameter int PAGES       = 4,
  parameter int COLS        = 528,
  parameter int PROG_CYCLES = 16,
  parameter int MAX_PARTIAL = 8,
  parameter int STUCK_PAGE  = 3,
  parameter int STUCK_COL   = 5,
  parameter int STUCK_BIT   = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic       rd_stb,
  input  logic [7:0] din,
  input  logic       wp_n,
  output logic [7:0] dout,
  output logic       ready
);

  localparam int              PW        = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int              CW        = $clog2(COLS + 1);
  localparam int              BW        = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0]   COL_END   = CW'(COLS);
  localparam logic [BW-1:0]   BUSY_LAST = BW'(PROG_CYCLES - 1);

  nps_state_e        state_q, state_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic              armed_q, armed_d;
  logic              loaded_q, loaded_d;
  logic [2:0]        acnt_q, acnt_d;
  logic [CW-1:0]     col_q, col_d;
  logic [PW-1:0]     page_q, page_d;
  logic              half_q, half_d;
  logic              stat_q, stat_d;
  logic              fail_q, fail_d;

  nps_cmd_t          cmd;
  logic              cmd_any;
  logic              busy;
  logic              commit;
  logic              buf_clr;
  logic              buf_we;
  logic [COLS*8-1:0] buf_bits;
  logic [7:0]        rd_byte;
  logic              prog_fail;

  assign busy    = (state_q == ST_BUSY);
  assign commit  = busy && (bcnt_q == '0) && !cmd.reset;
  assign buf_clr = cmd.load | cmd.reset;
  assign buf_we  = data_we && !cmd_we && !busy && armed_q &&
                   (acnt_q == 3'd4) && (col_q < COL_END);

  nps_cmd_decode u_dec (
    .cmd_we (cmd_we),
    .code   (din),
    .busy   (busy),
    .cmd    (cmd),
    .any    (cmd_any)
  );

  nps_page_buf #(.COLS(COLS), .CW(CW)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (buf_clr),
    .we    (buf_we),
    .col   (col_q),
    .din   (din),
    .bits  (buf_bits)
  );

  nps_array #(
    .PAGES(PAGES), .COLS(COLS), .PW(PW), .CW(CW), .MAX_PARTIAL(MAX_PARTIAL),
    .STUCK_PAGE(STUCK_PAGE), .STUCK_COL(STUCK_COL), .STUCK_BIT(STUCK_BIT)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .page      (page_q),
    .data      (buf_bits),
    .rd_col    (col_q),
    .rd_byte   (rd_byte),
    .prog_fail (prog_fail)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    armed_d  = armed_q;
    loaded_d = loaded_q;
    acnt_d   = acnt_q;
    col_d    = col_q;
    page_d   = page_q;
    half_d   = half_q;
    stat_d   = stat_q;
    fail_d   = fail_q;

    if (cmd_any) begin
      stat_d = cmd.status;
    end

    if (cmd.ptr_lo || cmd.ptr_hi) begin
      half_d   = cmd.ptr_hi;
      acnt_d   = 3'd0;
      armed_d  = 1'b0;
      loaded_d = 1'b0;
    end

    if (cmd.load) begin
      armed_d  = 1'b1;
      loaded_d = 1'b0;
      acnt_d   = 3'd0;
    end

    if (cmd.confirm) begin
      armed_d  = 1'b0;
      loaded_d = 1'b0;
      if (armed_q && loaded_q) begin
        state_d = ST_BUSY;
        bcnt_d  = BUSY_LAST;
      end
    end

    if (!cmd_we && !busy) begin
      if (addr_we && (acnt_q < 3'd4)) begin
        acnt_d = acnt_q + 3'd1;
        if (acnt_q == 3'd0) begin
          col_d = CW'({half_q, din});
        end else if (acnt_q == 3'd1) begin
          page_d = din[PW-1:0];
        end
      end else if (buf_we) begin
        col_d    = col_q + CW'(1);
        loaded_d = 1'b1;
      end else if (rd_stb && !stat_q && (col_q < COL_END)) begin
        col_d = col_q + CW'(1);
      end
    end

    if (busy) begin
      if (bcnt_q == '0) begin
        state_d = ST_IDLE;
        fail_d  = prog_fail;
      end else begin
        bcnt_d = bcnt_q - BW'(1);
      end
    end

    if (cmd.reset) begin
      state_d  = ST_IDLE;
      bcnt_d   = '0;
      armed_d  = 1'b0;
      loaded_d = 1'b0;
      acnt_d   = 3'd0;
      half_d   = 1'b0;
      fail_d   = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bcnt_q   <= '0;
      armed_q  <= 1'b0;
      loaded_q <= 1'b0;
      acnt_q   <= 3'd0;
      col_q    <= '0;
      page_q   <= '0;
      half_q   <= 1'b0;
      stat_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bcnt_q   <= bcnt_d;
      armed_q  <= armed_d;
      loaded_q <= loaded_d;
      acnt_q   <= acnt_d;
      col_q    <= col_d;
      page_q   <= page_d;
      half_q   <= half_d;
      stat_q   <= stat_d;
      fail_q   <= fail_d;
    end
  end

  assign ready = !busy;
  assign dout  = stat_q ? {wp_n, ready, 5'b00000, fail_q} : rd_byte;

endmodule

// File: rtl/nps_prog_seq_sva.sv
module nps_prog_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       ready,
  input logic       wp_n,
  input logic       stat_mode,
  input logic       pend,
  input logic       bcnt_zero
);

  // R1: the busy period only begins after a confirm strobe
  p_start_on_confirm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(ready)) |-> $past(cmd_we && din == 8'h10));

  // R3: a confirm without loaded data leaves the device ready
  p_confirm_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_we && din == 8'h10 && !pend) |=> ready);

  // R4: other strobes cannot end the busy period early
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !bcnt_zero && !(cmd_we && din == 8'hFF)) |=> !ready);

  // R5: status byte layout
  p_status_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_mode |-> (dout[7] == wp_n && dout[6] == ready && dout[5:1] == 5'b0));

  // R6: status mode persists until a command arrives
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_mode && !cmd_we) |=> stat_mode);

  // R10: reset command always returns to ready
  p_reset_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && din == 8'hFF) |=> ready);

endmodule

bind nps_prog_seq nps_prog_seq_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we),
  .din       (din),
  .dout      (dout),
  .ready     (ready),
  .wp_n      (wp_n),
  .stat_mode (stat_q),
  .pend      (armed_q & loaded_q),
  .bcnt_zero (bcnt_q == '0)
);

// File: tb/nps_prog_seq_tb.sv
`timescale 1ns/1ps
module nps_prog_seq_tb;

  localparam int PC   = 16;
  localparam int NCOL = 528;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_we, addr_we, data_we, rd_stb, wp_n;
  logic [7:0] din;
  logic [7:0] dout;
  logic       ready;

  int errors = 0;
  int checks = 0;
  int busy_tb = 0;

  logic [7:0] mm [4][NCOL];
  int         cnt_m [4];
  logic [7:0] dbuf [NCOL];

  always #2.5 clk = ~clk;

  nps_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we),
    .data_we(data_we), .rd_stb(rd_stb), .din(din), .wp_n(wp_n),
    .dout(dout), .ready(ready)
  );

  always @(negedge clk) if (!ready) busy_tb++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] b);
    @(negedge clk);
    din = b;
    cmd_we  = (kind == 0);
    addr_we = (kind == 1);
    data_we = (kind == 2);
    rd_stb  = (kind == 3);
    @(negedge clk);
    cmd_we = 0; addr_we = 0; data_we = 0; rd_stb = 0;
  endtask

  task automatic cmd(input logic [7:0] b);  strobe(0, b); endtask
  task automatic addr(input logic [7:0] b); strobe(1, b); endtask
  task automatic data(input logic [7:0] b); strobe(2, b); endtask
  task automatic rdstb();                   strobe(3, 8'h00); endtask

  function automatic logic [7:0] stat_exp(input bit rdy, input bit f);
    return {wp_n, rdy, 5'b00000, f};
  endfunction

  task automatic model_prog(input int pg, input int col, input int n, output bit f);
    logic [7:0] d, nb;
    f = 0;
    if (cnt_m[pg] >= 8) begin f = 1; return; end
    for (int c = 0; c < NCOL; c++) begin
      d  = (c >= col && c < col + n) ? dbuf[c - col] : 8'hFF;
      nb = mm[pg][c] & d;
      if (pg == 3 && c == 5) nb[0] = 1'b1;
      if ((~d & nb) != 8'h00) f = 1;
      mm[pg][c] = nb;
    end
    cnt_m[pg]++;
  endtask

  task automatic set_read(input int pg, input int s);
    if (s < 256) begin cmd(8'h00); addr(8'(s)); end
    else if (s < 512) begin cmd(8'h01); addr(8'(s - 256)); end
    else begin cmd(8'h01); addr(8'hFF); end
    addr(8'(pg)); addr(8'h00); addr(8'h00);
    if (s >= 512) repeat (s - 511) rdstb();
  endtask

  task automatic check_window(input int pg, input int s, input int len, input string req);
    logic [7:0] e;
    set_read(pg, s);
    for (int k = 0; k < len; k++) begin
      e = (s + k < NCOL) ? mm[pg][s + k] : 8'hFF;
      chk(dout == e, req, dout, e);
      rdstb();
    end
  endtask

  // load and confirm; inject=1 adds ignored strobes during busy
  task automatic do_program(input int pg, input int col, input int n, input bit inject,
                            input string req);
    int b0;
    bit f;
    if (col < 256) cmd(8'h00); else cmd(8'h01);
    cmd(8'h80);
    addr(8'(col % 256)); addr(8'(pg)); addr(8'h00); addr(8'h00);
    for (int i = 0; i < n; i++) data(dbuf[i]);
    b0 = busy_tb;
    cmd(8'h10);
    chk(ready == 1'b0, {req, " ready low"}, ready, 0);
    if (inject) begin
      cmd(8'h70);
      chk(dout[6] == 1'b0 && dout[7] == wp_n, "R5 busy status", dout, {wp_n, 7'b0});
      cmd(8'h80); addr(8'h05); data(8'h00); cmd(8'h10); cmd(8'h00);
    end
    while (!ready) @(negedge clk);
    chk(busy_tb - b0 == PC, "R1 busy length", busy_tb - b0, PC);
    model_prog(pg, col, n, f);
    if (inject) chk(dout == stat_exp(1, f), "R4 status kept", dout, stat_exp(1, f));
    cmd(8'h70);
    chk(dout == stat_exp(1, f), {req, " status"}, dout, stat_exp(1, f));
    check_window(pg, (col > 0) ? col - 1 : 0, n + 2, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s0;
    void'($urandom(32'd2024));
    cmd_we = 0; addr_we = 0; data_we = 0; rd_stb = 0; din = 0; wp_n = 1;
    for (int p = 0; p < 4; p++) begin
      cnt_m[p] = 0;
      for (int c = 0; c < NCOL; c++) mm[p][c] = 8'hFF;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 / R11 reset state
    chk(ready == 1'b1, "R12 ready after reset", ready, 1);
    chk(dout == 8'hFF, "R12 not status, erased byte", dout, 8'hFF);
    check_window(2, 200, 2, "R11 erased read");

    // R3 confirm without data
    cmd(8'h10);
    chk(ready == 1'b1, "R3 bare confirm", ready, 1);
    cmd(8'h80); addr(8'h10); addr(8'h00); addr(8'h00); addr(8'h00);
    cmd(8'h10);
    chk(ready == 1'b1, "R3 confirm after address only", ready, 1);
    cmd(8'h70);
    chk(dout == stat_exp(1, 0), "R3 no fail", dout, stat_exp(1, 0));

    // R1 basic program
    dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h00; dbuf[3] = 8'h7E;
    do_program(0, 10, 4, 0, "R1");

    // R7 AND combining, bits at 0 stay 0 without failure
    dbuf[0] = 8'hFF; dbuf[1] = 8'hF0; dbuf[2] = 8'hFF;
    do_program(0, 10, 3, 0, "R7");

    // R2 second half pointer and end of page
    for (int i = 0; i < 20; i++) dbuf[i] = 8'(i * 13);
    do_program(1, 300, 20, 0, "R2");
    for (int i = 0; i < 20; i++) dbuf[i] = 8'(8'h80 | i);
    do_program(1, 511, 20, 0, "R2 end");
    check_window(1, 525, 5, "R11 past end");

    // R4 ignored strobes during busy
    dbuf[0] = 8'h12;
    do_program(0, 40, 1, 1, "R4");
    check_window(0, 5, 2, "R4 injected data ignored");

    // R6 status sticky across read strobes, R5 write protect
    cmd(8'h70);
    s0 = dout;
    rdstb(); rdstb(); rdstb();
    chk(dout == s0, "R6 status across strobes", dout, s0);
    wp_n = 0;
    @(negedge clk);
    chk(dout[7] == 1'b0 && dout[6] == 1'b1, "R5 wp bit", dout, stat_exp(1, 0));
    wp_n = 1;
    check_window(0, 40, 1, "R6 leaves status");

    // R8 stuck-at-one cell
    dbuf[0] = 8'h01;
    do_program(3, 5, 1, 0, "R8 pass");
    dbuf[0] = 8'h00;
    do_program(3, 5, 1, 0, "R8 fail");
    cmd(8'h70);
    chk(dout[0] == 1'b1, "R8 fail bit", dout[0], 1);
    dbuf[0] = 8'hFF;
    do_program(3, 5, 1, 0, "R7 one on zero");

    // R10 abort
    cmd(8'h00); cmd(8'h80); addr(8'd40); addr(8'd1); addr(0); addr(0);
    data(8'h00); data(8'h00);
    cmd(8'h10);
    repeat (3) @(negedge clk);
    cmd(8'hFF);
    chk(ready == 1'b1, "R10 ready after abort", ready, 1);
    cmd(8'h70);
    chk(dout == stat_exp(1, 0), "R10 fail cleared", dout, stat_exp(1, 0));
    cmd(8'h10);
    chk(ready == 1'b1, "R10 no restart", ready, 1);
    check_window(1, 39, 4, "R10 array unchanged");

    // R9 partial program limit on page 2
    for (int i = 0; i < 9; i++) begin
      dbuf[0] = 8'h00;
      do_program(2, 20 + i * 7, 1, 0, "R9");
    end
    chk(mm[2][76] == 8'hFF, "R9 ninth refused", mm[2][76], 8'hFF);

    // constrained random programs
    for (int t = 0; t < 30; t++) begin
      int pg, col, n;
      pg  = $urandom_range(0, 3);
      col = $urandom_range(0, 511);
      n   = $urandom_range(1, 24);
      for (int i = 0; i < n; i++)
        dbuf[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      do_program(pg, col, n, ($urandom_range(0, 4) == 0), "R1 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule